// File: doc/BRIEF.md
# Trimmed-rate seconds counter with alarm

This block keeps a free-running count that advances at a programmable fraction of a 32.768 kHz reference. The reference reaches the block as `ref_tick`, a pulse that lasts one cycle of the system clock. A 16-bit down-counting prescaler sits between the reference and the count. It is reloaded from the low half of the trim register every time the count advances. With a trim of 32767 the count therefore advances once per second, and with a trim of 0 it advances on every reference pulse.

Two event flags sit beside the count. The first is an alarm flag, raised while the count equals a programmed match value and the alarm is enabled. The second is a tick flag, raised on each advance of the count while ticks are enabled. Each flag drives its own interrupt output. Software clears a flag by writing a 1 to its bit. The two enable bits in the same register are plain read/write bits.

Top module: `rtc_trim`

## Requirements
- R1: After reset the match, count, trim and status registers all read 0, and both interrupt outputs are low.
- R2: With trim low half T (bits 15:0 of the trim register at offset 0x08), the count at offset 0x04 advances by one on every (T+1)-th `ref_tick` pulse. Trim bits above 15 are stored and read back but do not affect the rate.
- R3: A write to the count loads the written value and reloads the prescaler from the current trim low half, so the next advance comes T+1 pulses after the write.
- R4: A write to the trim register reloads the prescaler from the written bits 15:0, so the next advance comes (new T)+1 pulses after the write.
- R5: A write to the status register (offset 0x10) sets alarm enable (bit 2) and tick enable (bit 3) directly from the written bits 2 and 3.
- R6: In the same status write, a 1 in bit 0 clears the alarm flag and a 1 in bit 1 clears the tick flag. A 0 in either bit leaves that flag unchanged.
- R7: The tick flag (status bit 1) is set at the clock edge where the count advances, provided tick enable is 1 before that edge. It is not set while tick enable is 0.
- R8: The alarm flag (status bit 0) is set one cycle after any cycle in which alarm enable is 1 and the count equals the match register (offset 0x00). While that condition holds, setting takes priority over a clear.
- R9: `alarm_irq` follows the alarm flag and `tick_irq` follows the tick flag.
- R10: A write to the count or to the trim register in the same cycle as a `ref_tick` pulse causes that pulse to be discarded.
- R11: Offsets other than 0x00, 0x04, 0x08 and 0x10 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, equal to the alarm flag |
| tick_irq | output | 1 | Tick interrupt, equal to the tick flag |

## Verification
The hardest situation to reach from the ports is the collision between register traffic and the prescaler. This covers a count or trim write that lands on the same cycle as a reference pulse, and a flag clear issued while the alarm match still holds. The random phase keeps trim values small so that advances happen often, and it places the match value a few counts ahead of the running count. It also raises `ref_tick` on most cycles, including write cycles, so these collisions occur many times. Directed sequences hit each of them once more, at known pulse counts.

// File: rtl/rtc_trim.sv
module rtc_trim #(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              alarm_irq,
  output logic              tick_irq
);
  localparam logic [ADDR_W-1:0] OFS_MATCH = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_TRIM  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(5'h10);

  logic [CNT_W-1:0] match_q, count_q, trim_q;
  logic [DIV_W-1:0] psc_q;
  logic             al_flag, hz_flag, al_en, hz_en;

  wire sel_match = wr_en && (addr == OFS_MATCH);
  wire sel_count = wr_en && (addr == OFS_COUNT);
  wire sel_trim  = wr_en && (addr == OFS_TRIM);
  wire sel_stat  = wr_en && (addr == OFS_STAT);

  wire [DIV_W-1:0] reload = trim_q[DIV_W-1:0];
  wire tick_ok = ref_tick && !sel_count && !sel_trim;
  wire advance = tick_ok && (psc_q == '0);
  wire hit     = al_en && (count_q == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      count_q <= '0;
      trim_q  <= '0;
      psc_q   <= '0;
      al_flag <= 1'b0;
      hz_flag <= 1'b0;
      al_en   <= 1'b0;
      hz_en   <= 1'b0;
    end else begin
      if (sel_match) match_q <= wdata;
      if (sel_trim) trim_q <= wdata;

      if (sel_count)    count_q <= wdata;
      else if (advance) count_q <= count_q + 1'b1;

      if (sel_trim)       psc_q <= wdata[DIV_W-1:0];
      else if (sel_count) psc_q <= reload;
      else if (tick_ok)   psc_q <= advance ? reload : psc_q - 1'b1;

      al_flag <= hit | (al_flag & ~(sel_stat & wdata[0]));
      hz_flag <= (advance & hz_en) | (hz_flag & ~(sel_stat & wdata[1]));

      if (sel_stat) begin
        al_en <= wdata[2];
        hz_en <= wdata[3];
      end
    end
  end

  always_comb begin
    unique case (addr)
      OFS_MATCH: rdata = match_q;
      OFS_COUNT: rdata = count_q;
      OFS_TRIM:  rdata = trim_q;
      OFS_STAT:  rdata = CNT_W'({hz_en, al_en, hz_flag, al_flag});
      default:   rdata = '0;
    endcase
  end

  assign alarm_irq = al_flag;
  assign tick_irq  = hz_flag;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> ($past(sel_count) || count_q == $past(count_q) + 1'b1));

  a_r2_psc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    psc_q <= reload);

  a_r7_tick_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hz_flag) |-> $past(hz_en && ref_tick));

  a_r8_alarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al_flag) |-> $past(hit));

  a_r6_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stat && wdata[0] && !hit) |=> !alarm_irq);

  a_r10_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_trim && !sel_count) |=> (count_q == $past(count_q)));
endmodule

// File: tb/rtc_trim_bench.sv
module rtc_trim_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        alarm_irq, tick_irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] m_match, m_count, m_trim;
  logic [15:0] m_psc;
  logic        m_af, m_hf, m_ae, m_he;

  always #10 clk = ~clk;

  rtc_trim u_rtc_trim (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_irq(alarm_irq), .tick_irq(tick_irq)
  );

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return m_match;
      5'h04: return m_count;
      5'h08: return m_trim;
      5'h10: return {28'd0, m_he, m_ae, m_hf, m_af};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_match = 0; m_count = 0; m_trim = 0; m_psc = 0;
    m_af = 0; m_hf = 0; m_ae = 0; m_he = 0;
  endtask

  // one clock: drive at negedge, advance model, compare irqs at next negedge
  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d,
                      input logic tk, input string tag);
    logic s_cnt, s_trm, s_sts, ok, adv, hit;
    logic [31:0] n_count; logic [15:0] n_psc; logic n_af, n_hf;
    wr_en = we; addr = a; wdata = d; ref_tick = tk;
    #1;
    if (!we) check({tag, " read"}, rdata, model_read(a));
    s_cnt = we && a == 5'h04; s_trm = we && a == 5'h08; s_sts = we && a == 5'h10;
    ok  = tk && !s_cnt && !s_trm;
    adv = ok && m_psc == 0;
    hit = m_ae && m_count == m_match;
    n_count = s_cnt ? d : (adv ? m_count + 1 : m_count);
    n_psc = s_trm ? d[15:0] : s_cnt ? m_trim[15:0] : ok ? (adv ? m_trim[15:0] : m_psc - 1) : m_psc;
    n_af = hit | (m_af & ~(s_sts & d[0]));
    n_hf = (adv & m_he) | (m_hf & ~(s_sts & d[1]));
    @(negedge clk);
    if (we && a == 5'h00) m_match = d;
    if (s_trm) m_trim = d;
    if (s_sts) begin m_ae = d[2]; m_he = d[3]; end
    m_count = n_count; m_psc = n_psc; m_af = n_af; m_hf = n_hf;
    check({tag, " R9 alarm_irq"}, {31'd0, alarm_irq}, {31'd0, m_af});
    check({tag, " R9 tick_irq"}, {31'd0, tick_irq}, {31'd0, m_hf});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b0, a, 32'd0, 1'b0, tag);
  endtask
  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 5'h04, 32'd0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(5'h00, "R1 match"); rd(5'h04, "R1 count");
    rd(5'h08, "R1 trim");  rd(5'h10, "R1 status");

    // R2 rate with trim 2, R7 tick flag with enable
    wr(5'h08, 32'h0000_0002, "R4 trim");
    wr(5'h10, 32'h8, "R5 enables");
    rd(5'h10, "R5 status");
    ticks(2, "R2");
    check("R2 no advance yet", rdata, 32'd0);
    ticks(1, "R7");
    check("R7 tick_irq after advance", {31'd0, tick_irq}, 32'd1);
    ticks(6, "R2");
    rd(5'h04, "R2 count");
    check("R2 count after 9 pulses", rdata, 32'd3);

    // R6 clear tick flag; 0 in bit leaves flag
    wr(5'h10, 32'h8, "R6 zero write");
    check("R6 flag kept", {31'd0, tick_irq}, 32'd1);
    wr(5'h10, 32'h2, "R6 clear");
    check("R6 flag cleared", {31'd0, tick_irq}, 32'd0);
    ticks(6, "R7 disabled");
    check("R7 no flag when disabled", {31'd0, tick_irq}, 32'd0);

    // R3 count write restarts prescaler
    ticks(1, "R3 phase");
    wr(5'h04, 32'h0000_0100, "R3 load");
    ticks(2, "R3");
    rd(5'h04, "R3 count held");
    ticks(1, "R3");
    rd(5'h04, "R3 count");
    check("R3 next advance", rdata, 32'h101);

    // R4 trim write with upper bits
    wr(5'h08, 32'hABCD_0001, "R4 trim upper");
    rd(5'h08, "R4 trim readback");
    ticks(4, "R4");
    rd(5'h04, "R4 count");
    check("R4 rate /2", rdata, 32'h103);

    // R10 write with coincident pulse
    wr(5'h08, 32'd0, "R4 trim0");
    step(1'b1, 5'h04, 32'h50, 1'b1, "R10 count write");
    rd(5'h04, "R10 count");
    check("R10 pulse dropped", rdata, 32'h50);
    step(1'b1, 5'h08, 32'd0, 1'b1, "R10 trim write");
    rd(5'h04, "R10 count after trim");
    check("R10 trim pulse dropped", rdata, 32'h50);

    // R8 alarm and priority of set over clear
    wr(5'h00, 32'h52, "R8 match");
    wr(5'h10, 32'h4, "R8 enable");
    ticks(2, "R8");
    check("R8 not yet", {31'd0, alarm_irq}, 32'd0);
    rd(5'h10, "R8");
    check("R8 alarm flag", {31'd0, alarm_irq}, 32'd1);
    wr(5'h10, 32'h5, "R8 clear while equal");
    check("R8 set beats clear", {31'd0, alarm_irq}, 32'd1);
    ticks(1, "R8");
    wr(5'h10, 32'h5, "R6 alarm clear");
    check("R6 alarm cleared", {31'd0, alarm_irq}, 32'd0);

    // R11 unmapped offsets
    wr(5'h0C, 32'hFFFF_FFFF, "R11 wr 0C");
    wr(5'h14, 32'hFFFF_FFFF, "R11 wr 14");
    wr(5'h1C, 32'hFFFF_FFFF, "R11 wr 1C");
    rd(5'h0C, "R11 rd 0C"); rd(5'h18, "R11 rd 18");
    rd(5'h00, "R11 match kept"); rd(5'h04, "R11 count kept");
    rd(5'h08, "R11 trim kept");  rd(5'h10, "R11 status kept");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      logic tk = ($urandom_range(0, 3) != 0);
      case (sel)
        0: step(1'b1, 5'h08, {$urandom_range(0, 255) << 16} | 32'($urandom_range(0, 3)), tk, "R4 rnd trim");
        1: step(1'b1, 5'h04, 32'($urandom_range(0, 40)), tk, "R3 rnd count");
        2: step(1'b1, 5'h00, m_count + 32'($urandom_range(0, 4)), tk, "R8 rnd match");
        3: step(1'b1, 5'h10, 32'($urandom_range(0, 15)), tk, "R6 rnd status");
        4: step(1'b1, 5'($urandom_range(0, 31)), $urandom, tk, "R11 rnd any");
        default: step(1'b0, 5'({$urandom_range(0, 4)} << 2), 32'd0, tk, "R2 rnd read");
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule